// File: doc/BRIEF.md
# Clocked Serial I/O Shifter

This block moves one byte at a time over a three-wire synchronous serial link. A single 8-bit register serves as both the transmit and the receive holding register. Writing a byte to it starts a transfer. On each sampling edge, one outgoing bit leaves on the data-out pin and one incoming bit from the data-in pin enters the register. Once the transfer ends, the received byte can be read back from the same register.

The transfer clock has two possible sources. In internal mode, a divider with an 8-bit reload value generates it. That clock stops by itself after eight pulses and rests at a level set by the polarity select. In external mode, the clock comes from an input pin. The pin is synchronised into the system clock domain and edge-detected there.

Configuration inputs select the bit order, the clock polarity and, in external mode, the level driven on data-out between transfers. A one-cycle completion pulse marks the end of every byte. A write made while a transfer is in flight is dropped and raises a sticky error flag.

Top module: `ser_shift_unit`

## Requirements
- R1: When `wr_en` is high and `busy` is low at a clock edge, `wr_data` is loaded into the register (readable on `rd_data`) and `busy` is high from the next cycle. `busy` falls together with the 8th sampling edge of the transfer.
- R2: In internal mode, with reload value n, `sclk_out` toggles exactly at system edges E0+j·(n+1) for j = 1..16, where E0 is the accepting write edge. One transfer-clock period is therefore 2·(n+1) system clocks.
- R3: In internal mode, `sclk_out` rests high when `cfg_pol`=0 and low when `cfg_pol`=1. It is at that level again after the 8th pulse.
- R4: With `cfg_msb_first`=1, bit 7 is sent first and each received bit enters at bit 0, shifting the register up. With `cfg_msb_first`=0, bit 0 is sent first and each received bit enters at bit 7, shifting the register down.
- R5: The launch edge is the clock edge leaving the resting level, and the sampling edge is the one returning to it. For `cfg_pol`=0 this means data changes on the falling edge and `sdi` is captured on the rising edge; for `cfg_pol`=1 it is the reverse. `done_irq` is high for exactly one cycle, right after the 8th sampling edge.
- R6: In internal mode, `sdo_oe` rises on the first launch edge. It stays high, holding the last bit, until n+1 clocks after completion. A write accepted during that hold drops `sdo_oe` on the next cycle.
- R7: In external mode, `sdo_oe` is always 1. `sdo` drives `cfg_idle_lvl` except between the first launch edge and the end of a transfer.
- R8: In external mode, a change on `sclk_in` sampled at system edge k acts at edge k+2. Sampling edges keep shifting the register after the 8th bit, without further `done_irq` pulses.
- R9: A write while `busy` is high leaves the register and the transfer unchanged and sets `wr_err`. `wr_err` is cleared by `err_clr`, and a new set in the same cycle wins over the clear.
- R10: After reset, `busy`, `done_irq`, `wr_err` and `rd_data` are 0. In internal mode `sdo_oe` is 0 and `sclk_out` is at its resting level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Current register contents (received byte after completion) |
| cfg_int_clk | input | 1 | 1 = internal divider clock, 0 = external clock pin |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_pol | input | 1 | Clock polarity select |
| cfg_idle_lvl | input | 1 | Level on data-out between transfers in external mode |
| div_val | input | 8 | Divider reload value n |
| err_clr | input | 1 | Clears the write-while-busy flag |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for data-out (0 = high impedance) |
| done_irq | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| wr_err | output | 1 | Sticky write-while-busy flag |

## Verification
Every result has a fixed latency, counted from the edge that accepts a write. `busy` rises on that edge. In internal mode, clock edge j falls at j·(n+1) cycles, and the completion pulse and the drop of `busy` come with edge 16. The output enable is released n+1 cycles after that. In external mode, a pin change acts two system edges after it is first sampled. The bench's behavioural model advances its own timeline by these counts on every rising edge. Inputs are driven shortly after the rising edge, and every output is compared with the model at the falling edge, so each check lands on the cycle in which the result is due.

// File: rtl/ss_pkg.sv
// Shared definitions for the clocked serial shifter.
// Assumes: one system clock domain; byte-wide transfers.
package ss_pkg;
    localparam int unsigned SS_BITS = 8;

    // Classified transfer-clock events, valid for one system cycle each.
    typedef struct packed {
        logic launch;   // clock leaves its resting level
        logic sample;   // clock returns to its resting level
    } ss_edge_t;
endpackage

// File: rtl/ss_clk_div.sv
// Transfer-clock divider: emits a one-cycle tick every (reload+1) system
// clocks while run is high. A restart zeroes the count and suppresses the
// tick in that cycle. Assumes reload is held stable during a transfer.
module ss_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && !restart && (cnt == reload);

    // Count up to the reload value, wrapping to zero on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else if (cnt == reload) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Ticks are separated by at least one idle cycle unless the reload is zero.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reload != '0) |=> (!tick || reload != $past(reload)));
endmodule

// File: rtl/ss_pin_edge.sv
// External clock pin synchroniser and edge classifier. Two flops
// synchronise the pin and a third holds the previous level. An edge toward
// the polarity level is a launch, an edge away from it is a sample.
// Assumes the pin toggles at most once every two system clocks.
module ss_pin_edge
    import ss_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    input  logic     pol,
    output ss_edge_t ev
);
    logic [2:0] sync;

    // Shift the pin level through the synchroniser; reset to the resting level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync <= {3{~pol}};
        end else begin
            sync <= {sync[1:0], pin};
        end
    end

    // Classify a level change seen at the synchroniser output.
    always_comb begin
        ev.launch = (sync[1] != sync[2]) && (sync[1] == pol);
        ev.sample = (sync[1] != sync[2]) && (sync[1] != pol);
    end
endmodule

// File: rtl/ss_shift_core.sv
// Shift engine: the shared transmit/receive register, the bit counter,
// the internal clock phase, output-enable hold and the status flags.
// Assumes configuration inputs change only while no transfer is active.
module ss_shift_core
    import ss_pkg::*;
#(
    parameter int DATA_W = SS_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              int_mode,
    input  logic              msb_first,
    input  logic              pol,
    input  logic              idle_lvl,
    input  logic              sdi,
    input  logic              err_clr,
    input  logic              tick,
    input  ss_edge_t          ext_ev,
    output logic [DATA_W-1:0] shreg_o,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              irq_o,
    output logic              busy_o,
    output logic              err_o,
    output logic              run_o,
    output logic              restart_o
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg, shifted;
    logic [BIT_W-1:0]  bits;
    logic busy, hold, active, sdo_q, sclk_q, irq_q, err_q;
    logic idle_clk, wr_ok, launch, sample, done, out_bit;

    // Decode this cycle's transfer events from the selected clock source.
    always_comb begin
        idle_clk = ~pol;
        wr_ok    = wr_en && !busy;
        if (int_mode) begin
            launch = tick && busy && (sclk_q == idle_clk);
            sample = tick && busy && (sclk_q != idle_clk);
        end else begin
            launch = busy && ext_ev.launch;
            sample = ext_ev.sample;
        end
        done    = sample && busy && (bits == LAST_BIT);
        out_bit = msb_first ? shreg[DATA_W-1] : shreg[0];
        shifted = msb_first ? {shreg[DATA_W-2:0], sdi} : {sdi, shreg[DATA_W-1:1]};
    end

    // Shared data register: load on an accepted write, shift on sampling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)      shreg <= '0;
        else if (wr_ok)  shreg <= wr_data;
        else if (sample) shreg <= shifted;
    end

    // Busy flag and count of sampled bits in the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            bits <= '0;
        end else if (wr_ok) begin
            busy <= 1'b1;
            bits <= '0;
        end else if (sample && busy) begin
            bits <= bits + 1'b1;
            if (done) busy <= 1'b0;
        end
    end

    // Outgoing bit register and the flag marking a launched transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q  <= 1'b0;
            active <= 1'b0;
        end else if (wr_ok) begin
            active <= 1'b0;
        end else if (launch) begin
            sdo_q  <= out_bit;
            active <= 1'b1;
        end else if (done) begin
            active <= 1'b0;
        end
    end

    // Half-period hold of data-out after an internal-clock transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                hold <= 1'b0;
        else if (wr_ok)            hold <= 1'b0;
        else if (done && int_mode) hold <= 1'b1;
        else if (tick && hold)     hold <= 1'b0;
    end

    // Internal transfer clock phase: toggles on ticks, parks at rest otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            sclk_q <= ~pol;
        else if (wr_ok)        sclk_q <= idle_clk;
        else if (tick && busy) sclk_q <= ~sclk_q;
        else if (!busy)        sclk_q <= idle_clk;
    end

    // Completion pulse and sticky write-while-busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            irq_q <= done;
            if (wr_en && busy) err_q <= 1'b1;
            else if (err_clr)  err_q <= 1'b0;
        end
    end

    assign shreg_o   = shreg;
    assign sclk_o    = sclk_q;
    assign sdo_o     = (int_mode || active) ? sdo_q : idle_lvl;
    assign sdo_oe_o  = int_mode ? (active || hold) : 1'b1;
    assign irq_o     = irq_q;
    assign busy_o    = busy;
    assign err_o     = err_q;
    assign run_o     = int_mode && (busy || hold);
    assign restart_o = wr_ok;

    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    p_irq_ends_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (!busy && $past(busy)));
    p_busy_write_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> err_q);
    p_idle_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en && int_mode) |=> $stable(shreg));
    p_clk_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && !busy && !hold && $stable(pol)) |-> (sclk_q == ~pol));
endmodule

// File: rtl/ser_shift_unit.sv
// Clocked serial I/O shifter top: ties the divider, the external clock
// edge classifier and the shift engine together. Assumes an external
// clock no faster than a quarter of the system clock.
module ser_shift_unit
    import ss_pkg::*;
#(
    parameter int DATA_W = SS_BITS,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cfg_int_clk,
    input  logic              cfg_msb_first,
    input  logic              cfg_pol,
    input  logic              cfg_idle_lvl,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              err_clr,
    input  logic              sclk_in,
    output logic              sclk_out,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              done_irq,
    output logic              busy,
    output logic              wr_err
);
    logic     tick, run, restart;
    ss_edge_t ext_ev;

    ss_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .reload  (div_val),
        .tick    (tick)
    );

    ss_pin_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sclk_in),
        .pol   (cfg_pol),
        .ev    (ext_ev)
    );

    ss_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .int_mode  (cfg_int_clk),
        .msb_first (cfg_msb_first),
        .pol       (cfg_pol),
        .idle_lvl  (cfg_idle_lvl),
        .sdi       (sdi),
        .err_clr   (err_clr),
        .tick      (tick),
        .ext_ev    (ext_ev),
        .shreg_o   (rd_data),
        .sclk_o    (sclk_out),
        .sdo_o     (sdo),
        .sdo_oe_o  (sdo_oe),
        .irq_o     (done_irq),
        .busy_o    (busy),
        .err_o     (wr_err),
        .run_o     (run),
        .restart_o (restart)
    );
endmodule

// File: tb/sim_ser_shift_unit.sv
// Bench: behavioural timeline model compared with the outputs every cycle.
module sim_ser_shift_unit;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, cfg_int_clk = 1, cfg_msb_first = 0, cfg_pol = 0, cfg_idle_lvl = 1;
    logic err_clr = 0, sclk_in = 1, sdi = 0;
    logic [7:0] wr_data = 8'h00, div_val = 8'h00;
    logic [7:0] rd_data;
    logic sclk_out, sdo, sdo_oe, done_irq, busy, wr_err;

    int checks = 0, errors = 0, irq_seen = 0, sdi_step = 0;
    bit fin = 0;

    // Model state
    bit m_ok = 0, mb, mh, mact, mirq, merr, msclk, msdo;
    int mt, mbits;
    logic [7:0] mreg;
    logic [3:0] hist;

    always #(CLK_P/2) clk = ~clk;

    ser_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cfg_int_clk(cfg_int_clk), .cfg_msb_first(cfg_msb_first), .cfg_pol(cfg_pol),
        .cfg_idle_lvl(cfg_idle_lvl), .div_val(div_val), .err_clr(err_clr),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .done_irq(done_irq), .busy(busy), .wr_err(wr_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model: advances a timeline of cycles since the write.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ok = 1; mb = 0; mh = 0; mact = 0; mirq = 0; merr = 0; msdo = 0;
            mt = 0; mbits = 0; mreg = 8'h00; msclk = ~cfg_pol; hist = {4{~cfg_pol}};
        end else begin
            bit pre_b, launch, sample;
            int half, j;
            pre_b = mb; launch = 0; sample = 0;
            half = int'(div_val) + 1;
            hist = {hist[2:0], sclk_in};
            mirq = 0;
            if (wr_en && pre_b) merr = 1;
            else if (err_clr) merr = 0;
            if (wr_en && !pre_b) begin
                mreg = wr_data; mb = 1; mbits = 0; mact = 0; mh = 0; mt = 0;
                msclk = ~cfg_pol;
            end else begin
                if (cfg_int_clk) begin
                    if (mb || mh) begin
                        mt++;
                        if (mt % half == 0) begin
                            j = mt / half;
                            if (mb) begin
                                if (j % 2 == 1) launch = 1; else sample = 1;
                                msclk = ~msclk;
                            end else mh = 0;
                        end
                    end
                end else if (hist[2] != hist[3]) begin
                    if (hist[2] == cfg_pol) launch = 1; else sample = 1;
                end
                if (launch && mb) begin
                    msdo = cfg_msb_first ? mreg[7] : mreg[0];
                    mact = 1;
                end
                if (sample && (mb || !cfg_int_clk))
                    mreg = cfg_msb_first ? {mreg[6:0], sdi} : {sdi, mreg[7:1]};
                if (sample && mb) begin
                    mbits++;
                    if (mbits == 8) begin
                        mb = 0; mirq = 1; mact = 0;
                        if (cfg_int_clk) mh = 1;
                    end
                end
                if (!pre_b) msclk = ~cfg_pol;
            end
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (m_ok && rst_n) begin
            bit e_oe, e_sdo;
            e_oe  = cfg_int_clk ? (mact || mh) : 1'b1;
            e_sdo = (cfg_int_clk || mact) ? msdo : cfg_idle_lvl;
            if (done_irq) irq_seen++;
            chk("R1 busy", busy, mb);
            chk("R2 sclk_out", sclk_out, msclk);
            chk("R5 done_irq", done_irq, mirq);
            chk(cfg_int_clk ? "R6 sdo_oe" : "R7 sdo_oe", sdo_oe, e_oe);
            if (e_oe) chk(cfg_int_clk ? "R4 sdo" : "R7 sdo", sdo, e_sdo);
            chk("R4 rd_data", rd_data, mreg);
            chk("R9 wr_err", wr_err, merr);
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        sdi_step++;
        sdi = sdi_step[0] ^ sdi_step[2] ^ sdi_step[3];
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic ext_pulse();
        sclk_in = cfg_pol;
        repeat (4) step();
        sclk_in = ~cfg_pol;
        repeat (4) step();
    endtask

    initial begin
        int irq_base;
        repeat (3) step();
        rst_n = 1;
        step();
        // R10 reset state
        chk("R10 busy", busy, 0);
        chk("R10 done_irq", done_irq, 0);
        chk("R10 wr_err", wr_err, 0);
        chk("R10 rd_data", rd_data, 0);
        chk("R10 sdo_oe", sdo_oe, 0);
        chk("R10 sclk_out", sclk_out, 1);

        // Internal clock, n=0, LSB first, polarity 0
        irq_base = irq_seen;
        write_byte(8'hA5);
        chk("R1 busy after write", busy, 1);
        repeat (16 + 3) step();
        chk("R3 clock parked high", sclk_out, 1);
        chk("R5 one pulse", irq_seen - irq_base, 1);

        // Internal clock, n=2, MSB first, polarity 1
        cfg_pol = 1; cfg_msb_first = 1; div_val = 8'd2;
        step();
        write_byte(8'h3C);
        repeat (16 * 3 + 6) step();
        chk("R3 clock parked low", sclk_out, 0);

        // Write while busy is dropped and flagged
        div_val = 8'd1;
        write_byte(8'h11);
        repeat (3) step();
        write_byte(8'hEE);
        chk("R9 flag set", wr_err, 1);
        repeat (40) step();
        err_clr = 1;
        step();
        err_clr = 0;
        chk("R9 flag cleared", wr_err, 0);

        // Hold window cut short by a new write
        cfg_pol = 0; cfg_msb_first = 0; div_val = 8'd3;
        step();
        write_byte(8'h5A);
        repeat (16 * 4) step();
        chk("R6 hold keeps oe", sdo_oe, 1);
        write_byte(8'h81);
        chk("R6 write cuts hold", sdo_oe, 0);
        repeat (16 * 4 + 8) step();

        // External clock, polarity 0, LSB first, idle level 1
        cfg_int_clk = 0; cfg_idle_lvl = 1;
        step();
        chk("R7 idle level", sdo, 1);
        irq_base = irq_seen;
        write_byte(8'hC3);
        repeat (2) step();
        for (int k = 0; k < 8; k++) ext_pulse();
        repeat (4) step();
        chk("R8 one pulse after eight edges", irq_seen - irq_base, 1);
        for (int k = 0; k < 2; k++) ext_pulse();
        repeat (4) step();
        chk("R8 no pulse for extra edges", irq_seen - irq_base, 1);
        chk("R8 not busy", busy, 0);

        // External clock, polarity 1, MSB first, idle level 0
        cfg_int_clk = 1; sclk_in = 0;
        repeat (5) step();
        cfg_pol = 1;
        step();
        cfg_int_clk = 0; cfg_idle_lvl = 0;
        step();
        chk("R7 idle level low", sdo, 0);
        write_byte(8'h96);
        repeat (2) step();
        for (int k = 0; k < 8; k++) ext_pulse();
        repeat (4) step();
        chk("R1 done", busy, 0);

        fin = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!fin) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule